// File: doc/BRIEF.md
# Per-Bank Precharge Timing Guard

This block sits in a memory controller next to one bank of a double-data-rate SDRAM. It watches the commands the scheduler sends to that bank (activate, read, read with auto-precharge, precharge) and tells the scheduler two things on every cycle. The first is whether a precharge issued at the coming clock edge would be legal. The second is whether an activate issued at that edge would be legal. A precharge is legal only if two conditions hold. The minimum activate-to-precharge time must have passed, and the last read must be able to finish its burst. An activate is legal only once the row-precharge time has run since the bank began to close.

For a read with auto-precharge, the guard decides on which edge the internal precharge starts and marks that cycle with a pulse. The chosen edge is the same one on which the earliest legal external precharge could have been issued. A precharge that arrives too early is flagged and dropped, and the bank stays open. The timing configuration is made of CAS latency, burst length code, tRAS in clocks and tRP in clocks. It is captured while reset is held and stays fixed until the next reset. tRP in clocks is the analog tRP divided by the clock period, rounded up, and the caller converts it before loading.

There is no data path in this block, so every pin is a plain control or status level and no back-pressure applies. Each command strobe is a one-cycle request that the guard either takes or ignores at the next rising edge.

Top module: `pcg_bank_guard`

## Requirements
- R1: While `rst_n` is low the four configuration inputs are captured. After reset the bank is closed: `act_ok`=1, `pre_ok`=0, `apre_start`=0, and `pre_reject`=0 while `cmd_pre` is low.
- R2: After an activate accepted at edge A, `pre_ok` stays low in every cycle whose closing edge is earlier than A+tRAS. This applies to auto-precharge too: `apre_start` cannot pulse before that edge.
- R3: The burst code (`cfg_burst_code` 1, 2, 3 gives a burst of 2, 4, 8 words, two words per clock) sets the read window. After a read accepted at edge R, the last data falls at edge R+CL+words/2. The earliest precharge that does not cut the burst short is CL edges before that, at R+words/2, so `pre_ok` stays low before that edge. The first edge with `pre_ok` high is max(A+tRAS, R+words/2).
- R4: After a precharge begins at edge P (external or internal), `act_ok` is low until the cycle whose closing edge is P+tRP, and it is high from that cycle on.
- R5: For a read with auto-precharge at edge R, `apre_start` is high in exactly one cycle: the one whose closing edge is max(A+tRAS, R+words/2). The internal precharge starts at that edge. `pre_ok` stays low while the auto-precharge is pending.
- R6: A precharge requested while `pre_ok` is low raises `pre_reject` in that same cycle and is not accepted. The bank stays open, `act_ok` stays low, and the normal earliest precharge edge is unchanged.
- R7: With a 2-word burst, a precharge on the edge right after a read is allowed once tRAS is met. One clock between read and precharge is enough.
- R8: An activate while `act_ok` is low is ignored and does not restart the tRAS count. A read while the bank is not open is ignored and does not delay a later precharge.
- R9: The earliest precharge edge after a read does not depend on CAS latency: CL 2 and CL 3 give the same edge for the same burst and tRAS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_cas_lat | input | 2 | CAS latency in clocks (2 or 3) |
| cfg_burst_code | input | 2 | Burst length code: 1=2 words, 2=4 words, 3=8 words |
| cfg_ras_cycles | input | 6 | tRAS in clocks (at least 1) |
| cfg_rp_cycles | input | 4 | tRP in clocks, already rounded up (at least 1) |
| cmd_act | input | 1 | Activate request for the coming edge |
| cmd_rd | input | 1 | Read request for the coming edge |
| cmd_rd_ap | input | 1 | Read with auto-precharge request for the coming edge |
| cmd_pre | input | 1 | Precharge request for the coming edge |
| pre_ok | output | 1 | A precharge at the coming edge would be accepted |
| act_ok | output | 1 | An activate at the coming edge would be accepted |
| apre_start | output | 1 | The internal auto-precharge begins at the coming edge |
| pre_reject | output | 1 | The precharge requested this cycle is refused |

## Verification
The properties assume that the scheduler raises at most one command strobe per cycle and changes the configuration only while reset is held. They also assume tRAS and tRP are at least one clock and the burst code is 1 to 3. Under those assumptions they check the following at the ports. An accepted or automatic close never comes before the tRAS count kept in the checker. `act_ok` never returns before tRP. The auto-precharge pulse lasts one cycle. A refused precharge leaves the bank open. The stimulus reloads the configuration through a fresh reset for every vector. It drives one strobe at a time and uses only the supported latency and burst codes.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int CL_W  = 2;
  localparam int BLC_W = 2;
  localparam int RAS_W = 6;
  localparam int RP_W  = 4;
  localparam int RD_W  = 4;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_CLOSING
  } bank_st_e;

  typedef struct packed {
    logic [CL_W-1:0]  cl;
    logic [BLC_W-1:0] blc;
    logic [RAS_W-1:0] tras;
    logic [RP_W-1:0]  trp;
  } guard_cfg_t;
endpackage

// File: rtl/pcg_since.sv
// Counts edges since the last start pulse, saturating at all ones.
module pcg_since #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic [W-1:0] elapsed
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      elapsed <= SAT;
    else if (start)
      elapsed <= W'(1);
    else if (elapsed != SAT)
      elapsed <= elapsed + W'(1);
  end
endmodule

// File: rtl/pcg_cfg_hold.sv
// Captures the timing configuration while reset is held.
module pcg_cfg_hold
  import pcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  guard_cfg_t cfg_in,
  output guard_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= cfg_in;
  end
endmodule

// File: rtl/pcg_read_window.sv
// Decides whether a precharge at the coming edge leaves the last read burst intact.
module pcg_read_window
  import pcg_pkg::*;
(
  input  logic [RD_W-1:0]  since_rd,
  input  logic [CL_W-1:0]  cas_lat,
  input  logic [BLC_W-1:0] bl_code,
  output logic             window_clear
);
  localparam int SW = RD_W + 2;

  logic [SW-1:0] half_beats;
  logic [SW-1:0] last_data;
  logic [SW-1:0] candidate;

  always_comb begin
    half_beats   = SW'(1) << ((bl_code == '0) ? BLC_W'(0) : bl_code - BLC_W'(1));
    last_data    = SW'(cas_lat) + half_beats;
    // precharge edge shifted by CL must not land before the last data edge
    candidate    = SW'(since_rd) + SW'(cas_lat);
    window_clear = candidate >= last_data;
  end
endmodule

// File: rtl/pcg_bank_guard.sv
module pcg_bank_guard
  import pcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CL_W-1:0]  cfg_cas_lat,
  input  logic [BLC_W-1:0] cfg_burst_code,
  input  logic [RAS_W-1:0] cfg_ras_cycles,
  input  logic [RP_W-1:0]  cfg_rp_cycles,
  input  logic             cmd_act,
  input  logic             cmd_rd,
  input  logic             cmd_rd_ap,
  input  logic             cmd_pre,
  output logic             pre_ok,
  output logic             act_ok,
  output logic             apre_start,
  output logic             pre_reject
);
  guard_cfg_t cfg_in, cfg_q;
  bank_st_e   state_q, state_d;
  logic       apre_pend_q;

  logic [RAS_W-1:0] ras_el;
  logic [RD_W-1:0]  rd_el;
  logic [RP_W-1:0]  rp_el;

  logic act_go, rd_go, pre_go, close_go;
  logic ras_met, rd_met, rp_met, is_open;

  assign cfg_in = '{cl: cfg_cas_lat, blc: cfg_burst_code,
                    tras: cfg_ras_cycles, trp: cfg_rp_cycles};

  pcg_cfg_hold u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  pcg_since #(.W(RAS_W)) u_since_act (
    .clk(clk), .rst_n(rst_n), .start(act_go), .elapsed(ras_el)
  );

  pcg_since #(.W(RD_W)) u_since_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_go), .elapsed(rd_el)
  );

  pcg_since #(.W(RP_W)) u_since_close (
    .clk(clk), .rst_n(rst_n), .start(close_go), .elapsed(rp_el)
  );

  pcg_read_window u_rdwin (
    .since_rd     (rd_el),
    .cas_lat      (cfg_q.cl),
    .bl_code      (cfg_q.blc),
    .window_clear (rd_met)
  );

  assign is_open = (state_q == BK_OPEN);
  assign ras_met = (ras_el >= cfg_q.tras);
  assign rp_met  = (rp_el >= cfg_q.trp);

  assign act_ok     = (state_q == BK_IDLE) || ((state_q == BK_CLOSING) && rp_met);
  assign pre_ok     = is_open && ras_met && rd_met && !apre_pend_q;
  assign apre_start = is_open && apre_pend_q && ras_met && rd_met;
  assign pre_reject = cmd_pre && !pre_ok;

  assign act_go   = cmd_act && act_ok;
  assign rd_go    = (cmd_rd || cmd_rd_ap) && is_open && !apre_pend_q;
  assign pre_go   = cmd_pre && pre_ok;
  assign close_go = pre_go || apre_start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BK_IDLE:    if (act_go) state_d = BK_OPEN;
      BK_OPEN:    if (close_go) state_d = BK_CLOSING;
      BK_CLOSING: if (act_go) state_d = BK_OPEN;
      default:    state_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= BK_IDLE;
      apre_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (close_go)
        apre_pend_q <= 1'b0;
      else if (rd_go && cmd_rd_ap)
        apre_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pcg_bank_guard_chk.sv
module pcg_bank_guard_chk
  import pcg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_act,
  input logic       cmd_pre,
  input logic       pre_ok,
  input logic       act_ok,
  input logic       apre_start,
  input bank_st_e   state_q,
  input guard_cfg_t cfg_q
);
  logic [7:0] since_act;
  logic [7:0] since_close;
  logic       closing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act   <= 8'hFF;
      since_close <= 8'hFF;
      closing     <= 1'b0;
    end else begin
      if (cmd_act && act_ok) since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
      if ((cmd_pre && pre_ok) || apre_start) begin
        since_close <= 8'd1;
        closing     <= 1'b1;
      end else begin
        if (since_close != 8'hFF) since_close <= since_close + 8'd1;
        if (cmd_act && act_ok) closing <= 1'b0;
      end
    end
  end

  AST_RAS_BEFORE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_ok || apre_start) |-> (since_act >= 8'(cfg_q.tras))); // R2

  AST_RP_BEFORE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (closing && act_ok) |-> (since_close >= 8'(cfg_q.trp))); // R4

  AST_NO_DUAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_ok && act_ok)); // R1

  AST_APRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    apre_start |=> (!apre_start && !pre_ok)); // R5

  AST_REJECT_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BK_OPEN && cmd_pre && !pre_ok && !apre_start) |=> (state_q == BK_OPEN)); // R6
endmodule

bind pcg_bank_guard pcg_bank_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_act    (cmd_act),
  .cmd_pre    (cmd_pre),
  .pre_ok     (pre_ok),
  .act_ok     (act_ok),
  .apre_start (apre_start),
  .state_q    (state_q),
  .cfg_q      (cfg_q)
);

// File: tb/pcg_bank_guard_test.sv
`timescale 1ns/1ps
module pcg_bank_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_cas_lat = 2'd2;
  logic [1:0] cfg_burst_code = 2'd3;
  logic [5:0] cfg_ras_cycles = 6'd6;
  logic [3:0] cfg_rp_cycles = 4'd3;
  logic       cmd_act = 1'b0, cmd_rd = 1'b0, cmd_rd_ap = 1'b0, cmd_pre = 1'b0;
  logic       pre_ok, act_ok, apre_start, pre_reject;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcg_bank_guard uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cas_lat(cfg_cas_lat), .cfg_burst_code(cfg_burst_code),
    .cfg_ras_cycles(cfg_ras_cycles), .cfg_rp_cycles(cfg_rp_cycles),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_rd_ap(cmd_rd_ap), .cmd_pre(cmd_pre),
    .pre_ok(pre_ok), .act_ok(act_ok), .apre_start(apre_start), .pre_reject(pre_reject)
  );

  // columns: CL, burst code, tRAS, tRP, read offset, auto, expected precharge offset, expected tRP gap
  localparam int ROWS = 8;
  localparam int VEC [ROWS][8] = '{
    '{2, 3, 6, 3, 1, 0, 6, 3},
    '{2, 3, 3, 2, 2, 0, 6, 2},
    '{3, 3, 3, 2, 2, 0, 6, 2},
    '{2, 2, 5, 4, 1, 1, 5, 4},
    '{3, 3, 2, 1, 1, 1, 5, 1},
    '{2, 1, 1, 2, 1, 0, 2, 2},
    '{3, 2, 8, 5, 3, 1, 8, 5},
    '{2, 1, 4, 3, 1, 1, 4, 3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic do_reset(input int cl, input int blc, input int tras, input int trp);
    rst_n = 1'b0;
    cfg_cas_lat = 2'(cl);
    cfg_burst_code = 2'(blc);
    cfg_ras_cycles = 6'(tras);
    cfg_rp_cycles = 4'(trp);
    cmd_act = 0; cmd_rd = 0; cmd_rd_ap = 0; cmd_pre = 0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  // From the current point, waits for act_ok; returns gap in edges after the close edge.
  task automatic wait_act(output int gap);
    gap = 0;
    for (int t = 1; t <= 40 && gap == 0; t++) begin
      #1;
      if (act_ok) gap = t;
      else tick();
    end
  endtask

  initial begin
    int found, gap, kind_ok;

    // R1 reset state
    do_reset(2, 3, 6, 3);
    #1;
    check(act_ok == 1'b1, "R1 act_ok", int'(act_ok), 1);
    check(pre_ok == 1'b0, "R1 pre_ok", int'(pre_ok), 0);
    check(apre_start == 1'b0 && pre_reject == 1'b0, "R1 pulses",
          int'({apre_start, pre_reject}), 0);

    // table: R2 R3 R4 R5 R7 R9
    for (int r = 0; r < ROWS; r++) begin
      do_reset(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3]);
      cmd_act = 1;
      tick();
      cmd_act = 0;
      found = 0;
      kind_ok = 0;
      for (int c = 1; c <= 64 && found == 0; c++) begin
        if (c == VEC[r][4]) begin
          if (VEC[r][5] != 0) cmd_rd_ap = 1; else cmd_rd = 1;
        end
        #1;
        if (c > VEC[r][4] && (pre_ok || apre_start)) begin
          found = c;
          kind_ok = (VEC[r][5] != 0) ? int'(apre_start && !pre_ok) : int'(pre_ok && !apre_start);
          if (VEC[r][5] == 0) cmd_pre = 1;
        end
        tick();
        cmd_rd = 0; cmd_rd_ap = 0; cmd_pre = 0;
      end
      check(found == VEC[r][6], $sformatf("R2 R3 R9 row %0d first close edge", r), found, VEC[r][6]);
      check(kind_ok == 1, $sformatf("R5 row %0d close kind", r), kind_ok, 1);
      wait_act(gap);
      check(gap == VEC[r][7], $sformatf("R4 row %0d tRP gap", r), gap, VEC[r][7]);
    end

    // R6 rejection and R8 ignored activate
    do_reset(2, 3, 6, 3);
    cmd_act = 1;
    tick();
    cmd_act = 0;
    cmd_pre = 1;
    #1;
    check(pre_reject == 1'b1, "R6 reject flag", int'(pre_reject), 1);
    tick();
    cmd_pre = 0;
    #1;
    check(act_ok == 1'b0 && pre_ok == 1'b0, "R6 bank stays open", int'({act_ok, pre_ok}), 0);
    found = 0;
    for (int c = 2; c <= 40 && found == 0; c++) begin
      if (c == 3) cmd_act = 1;  // R8 ignored while open
      #1;
      if (pre_ok) begin
        found = c;
        cmd_pre = 1;
      end
      tick();
      cmd_act = 0; cmd_pre = 0;
    end
    check(found == 6, "R6 R8 precharge edge unchanged", found, 6);
    wait_act(gap);
    check(gap == 3, "R6 close after rejection", gap, 3);

    // R8 read while closing is ignored
    do_reset(2, 3, 2, 2);
    cmd_act = 1;
    tick();
    cmd_act = 0;
    tick();           // edge A+1
    cmd_pre = 1;      // edge A+2 = P
    #1;
    check(pre_ok == 1'b1, "R8 setup precharge", int'(pre_ok), 1);
    tick();
    cmd_pre = 0;
    cmd_rd = 1;       // edge P+1, bank closing
    tick();
    cmd_rd = 0;
    cmd_act = 1;      // edge P+2
    #1;
    check(act_ok == 1'b1, "R8 act after tRP", int'(act_ok), 1);
    tick();
    cmd_act = 0;
    #1;
    check(pre_ok == 1'b0, "R8 pre before tRAS", int'(pre_ok), 0);
    tick();
    #1;
    check(pre_ok == 1'b1, "R8 stray read had no effect", int'(pre_ok), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule